// File: doc/BRIEF.md
# Contrast Level PWM Generator

This block drives a single pulse-width-modulated line whose average level, once smoothed by an external RC network, sets a display bias or contrast voltage. An 8-bit counter runs freely through 256 steps per period, advancing once every 1, 2, 4 or 8 system clocks as chosen by a 2-bit rate select. Each step, the counter is compared with a software compare value. While the counter is below that value, the output carries a programmable polarity level. For the rest of the period it carries the opposite level.

The compare value and the polarity are copied into shadow registers only at the wrap from 255 to 0. A write made partway through a period therefore never truncates or stretches the pulse in progress. While the block is disabled, the counter and the rate divider are held at zero and the output rests at the inverse of the polarity input. Setting the enable bit starts a fresh period at count zero, using the settings present at that moment.

Top module: `contrast_pwm`

## Requirements
- R1: The counter is 8 bits wide and increases by one on each prescaler tick. It wraps from 255 to 0, so one period lasts 256 ticks.
- R2: While enabled, the output equals the shadowed polarity bit when the counter is strictly below the shadowed compare value. Otherwise it equals the inverse of that bit. A polarity of 1 gives high pulses and a polarity of 0 gives low pulses.
- R3: At count 255 the output is always the inverse of the polarity. A compare value of 0 gives no polarity time in a period, and a compare value of 255 gives 255 of the 256 steps.
- R4: `ps_sel` codes 0, 1, 2 and 3 make the counter advance once every 1, 2, 4 and 8 clocks respectively. The time at the polarity level in one period is therefore the compare value × 2^code clocks.
- R5: A change to `cmp` or `pol` made while enabled takes effect only from the first step after the counter next wraps from 255 to 0.
- R6: While `en` is 0, the counter and the divider stay at zero and `pwm_out` equals the inverse of the live `pol` input. When `en` is raised, the first clock is step 0 of a period that uses the current `cmp` and `pol`.
- R7: A synchronous active-high `rst` clears the counter and the divider. On the clock after `rst` is released with `en` high, a new period starts at step 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; 0 holds the counter at zero |
| pol | input | 1 | Level driven while the count is below compare |
| ps_sel | input | 2 | Rate select: steps every 2^ps_sel clocks |
| cmp | input | 8 | Compare value |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a 2-bit rate select. This keeps a full period short enough to walk clock by clock even at the divide-by-8 rate. With these values, the bench measures the exact on-time in complete periods for every rate code, for both polarities, and at the compare extremes 0 and 255. It also checks a mid-period rewrite of the compare value and the polarity, an asynchronous-looking reset in the middle of a period, and how the output follows the live polarity while the block is disabled.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // default geometry of the contrast generator
    localparam int CPWM_CNT_W = 8;
    localparam int CPWM_PS_W  = 2;

    // named rate codes
    typedef enum logic [CPWM_PS_W-1:0] {
        RATE_DIV1 = 2'd0,
        RATE_DIV2 = 2'd1,
        RATE_DIV4 = 2'd2,
        RATE_DIV8 = 2'd3
    } cpwm_rate_e;

    // state presented to the compare stage each clock
    typedef struct packed {
        logic                  pol;
        logic [CPWM_CNT_W-1:0] cmp;
    } cpwm_shadow_t;

    // last divider value before a tick for a given rate code
    function automatic logic [31:0] div_last(input logic [7:0] code);
        return (32'd1 << code) - 32'd1;
    endfunction

endpackage

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
    parameter int PS_W = cpwm_pkg::CPWM_PS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [PS_W-1:0] ps_sel,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last;

    always_comb begin
        last = DIV_W'(cpwm_pkg::div_last(8'(ps_sel)));
        // >= keeps a shrinking rate from running the divider the long way round
        tick = (div_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
    parameter int CNT_W = cpwm_pkg::CPWM_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign wrap = tick && (cnt_q == CNT_MAX);
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare #(
    parameter int CNT_W = cpwm_pkg::CPWM_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wrap,
    input  logic             pol,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] sh_cmp,
    output logic             sh_pol,
    output logic             pwm_out
);
    logic [CNT_W-1:0] sh_cmp_q;
    logic             sh_pol_q;
    logic             below;

    // settings are captured only at period boundaries or while idle
    always_ff @(posedge clk) begin
        if (rst || !en || wrap) begin
            sh_cmp_q <= cmp;
            sh_pol_q <= pol;
        end
    end

    always_comb begin
        below   = (cnt < sh_cmp_q);
        if (en) begin
            pwm_out = below ? sh_pol_q : ~sh_pol_q;
        end else begin
            pwm_out = ~pol;
        end
    end

    assign sh_cmp = sh_cmp_q;
    assign sh_pol = sh_pol_q;
endmodule

// File: rtl/contrast_pwm.sv
module contrast_pwm #(
    parameter int CNT_W = cpwm_pkg::CPWM_CNT_W,
    parameter int PS_W  = cpwm_pkg::CPWM_PS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pol,
    input  logic [PS_W-1:0]  ps_sel,
    input  logic [CNT_W-1:0] cmp,
    output logic             pwm_out
);
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] sh_cmp;
    logic             sh_pol;

    cpwm_prescaler #(.PS_W(PS_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .ps_sel (ps_sel),
        .tick   (tick)
    );

    cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .tick (tick),
        .cnt  (cnt_q),
        .wrap (wrap)
    );

    cpwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wrap    (wrap),
        .pol     (pol),
        .cmp     (cmp),
        .cnt     (cnt_q),
        .sh_cmp  (sh_cmp),
        .sh_pol  (sh_pol),
        .pwm_out (pwm_out)
    );
endmodule

// File: rtl/cpwm_chk.sv
module cpwm_chk #(
    parameter int CNT_W = cpwm_pkg::CPWM_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             pol,
    input logic             pwm_out,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] sh_cmp,
    input logic             sh_pol
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && tick) |=> (cnt == $past(cnt) + 1'b1));

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> (cnt == $past(cnt)));

    // R3
    top_level_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == TOP) |-> (pwm_out == ~sh_pol));

    // R5
    shadow_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !(tick && cnt == TOP)) |=> ($stable(sh_cmp) && $stable(sh_pol)));

    // R6
    idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

    // R6
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (pwm_out == ~pol));
endmodule

bind contrast_pwm cpwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .pol     (pol),
    .pwm_out (pwm_out),
    .tick    (tick),
    .cnt     (cnt_q),
    .sh_cmp  (sh_cmp),
    .sh_pol  (sh_pol)
);

// File: tb/sim_contrast_pwm.sv
`timescale 1ns/1ps
module sim_contrast_pwm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       pol = 1'b1;
    logic [1:0] ps_sel = 2'd0;
    logic [7:0] cmp = 8'd0;
    logic       pwm_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    contrast_pwm u0 (
        .clk(clk), .rst(rst), .en(en), .pol(pol),
        .ps_sel(ps_sel), .cmp(cmp), .pwm_out(pwm_out)
    );

    // fields: rate code, polarity, compare, expected clocks at polarity level
    localparam int NV = 7;
    localparam logic [22:0] VEC [NV] = '{
        {2'd0, 1'b1, 8'd0,   12'd0},
        {2'd0, 1'b1, 8'd255, 12'd255},
        {2'd1, 1'b0, 8'd100, 12'd200},
        {2'd2, 1'b1, 8'd1,   12'd4},
        {2'd3, 1'b1, 8'd37,  12'd296},
        {2'd0, 1'b0, 8'd128, 12'd128},
        {2'd3, 1'b0, 8'd255, 12'd2040}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts clocks at level lvl over n clocks; sampled 1 ns after a falling edge
    task automatic count_level(input int n, input logic lvl, output int hits,
                               output logic first, output logic last);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            if (i == 0) first = pwm_out;
            if (i == n - 1) last = pwm_out;
            if (pwm_out == lvl) hits++;
            @(negedge clk);
        end
    endtask

    initial begin
        int   hits;
        int   tot;
        logic f, l;
        logic [1:0] vps;
        logic       vpol;
        logic [7:0] vcmp;
        int         vexp;

        // reset state: disabled output is the inverse of pol (R7, R6)
        repeat (3) @(negedge clk);
        #1 check(pwm_out == 1'b0, "R7 reset idle level", pwm_out, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // table walk: on-time per period for each rate, polarity, compare (R1 R2 R3 R4)
        for (int v = 0; v < NV; v++) begin
            {vps, vpol, vcmp} = VEC[v][22:12];
            vexp = int'(VEC[v][11:0]);
            en = 1'b0; ps_sel = vps; pol = vpol; cmp = vcmp;
            repeat (2) @(negedge clk);
            en = 1'b1;
            tot = 256 << vps;
            count_level(tot, vpol, hits, f, l);
            check(hits == vexp, "R4 on-time per period", hits, vexp);
            check(f == ((vcmp != 0) ? vpol : ~vpol), "R2 level at step 0", f,
                  (vcmp != 0) ? vpol : ~vpol);
            check(l == ~vpol, "R3 level at step 255", l, ~vpol);
        end

        // disabled: output follows the live polarity inverted (R6)
        en = 1'b0; pol = 1'b0;
        @(negedge clk);
        #1 check(pwm_out == 1'b1, "R6 idle follows pol=0", pwm_out, 1);
        pol = 1'b1;
        #1 check(pwm_out == 1'b0, "R6 idle follows pol=1", pwm_out, 0);

        // mid-period rewrite waits for the wrap (R5)
        @(negedge clk);
        ps_sel = 2'd0; pol = 1'b1; cmp = 8'd10;
        @(negedge clk);
        en = 1'b1;
        count_level(50, 1'b1, hits, f, l);
        check(hits == 10, "R5 first part of old period", hits, 10);
        cmp = 8'd200; pol = 1'b0;
        count_level(206, 1'b1, hits, f, l);
        check(hits == 0, "R5 old settings hold to wrap", hits, 0);
        count_level(256, 1'b0, hits, f, l);
        check(hits == 200, "R5 new settings after wrap", hits, 200);
        check(f == 1'b0, "R5 new polarity at step 0", f, 0);

        // reset mid-period restarts at step 0 (R7)
        en = 1'b0; pol = 1'b1; cmp = 8'd100;
        @(negedge clk);
        en = 1'b1;
        count_level(150, 1'b1, hits, f, l);
        check(l == 1'b0, "R7 pre-reset level at step 149", l, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        count_level(256, 1'b1, hits, f, l);
        check(f == 1'b1, "R7 step 0 after reset", f, 1);
        check(hits == 100, "R7 full period after reset", hits, 100);

        // rate code 1 fine check: step 0 lasts two clocks (R4, R1)
        en = 1'b0; ps_sel = 2'd1; pol = 1'b1; cmp = 8'd1;
        @(negedge clk);
        en = 1'b1;
        count_level(3, 1'b1, hits, f, l);
        check(hits == 2, "R4 divide-by-2 step width", hits, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule